// File: doc/BRIEF.md
# Fused Multiply-Accumulate Custom Instruction Unit

This unit sits beside the decode and execute stages of a small four-stage (fetch, decode, execute, writeback) RISC core. It recognises one custom 32-bit instruction word and executes it. In the decode stage it matches the word, names the two source registers to the core's register file and captures their values. In the following execute stage it combines those values with a private accumulator into one fused shift, add and multiply result. That result goes out as an ordinary writeback request (flag, destination index, data) and is loaded into the accumulator on the same edge.

Both source operands go through forwarding twice. At decode, the value just read from the register file is replaced by any write that the writeback stage is making to the same index. At execute, the captured value is replaced again if the instruction now in writeback targets that index. The writeback-stage source is the unit's own registered result when it is valid, and otherwise the core's forwarding inputs. A stall input holds the decode-to-execute register and the accumulator. While the stall lasts, the held operand values keep taking forwarded data, so a producer that retires during the stall is not missed.

Top module: `xunit`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is 1, `stall` is 0, bits [31:16] equal 16'h0D54 and the sub-opcode in bits [15:12] equals 4'h2. Any other word is rejected, including sub-opcode 4'h0 (the unassigned default), any other sub-opcode and any prefix with a bit flipped. A rejected word produces no writeback and leaves the accumulator unchanged.
- R2: The fields are destination Rd = bits [11:8], first source Rn = bits [7:4] and second source Rm = bits [3:0]. `rs_idx_a` shows Rn and `rs_idx_b` shows Rm combinationally from `instr`.
- R3: The result is d = a*b + (a<<2) + (b>>1) + ACC, taken modulo 2^32. Here a is the Rn value, b is the Rm value and ACC is the accumulator. The product keeps its low 32 bits and b>>1 is a logical shift.
- R4: An instruction accepted at clock edge k drives `wb_valid` high for exactly the one cycle after edge k+1, with `wb_idx` equal to Rd and `wb_data` equal to d, provided no stall occurs in between.
- R5: The accumulator loads d on the same edge that raises `wb_valid`, and changes at no other time. Back-to-back instructions therefore chain through it.
- R6: After reset `wb_valid` is 0 and the accumulator is 0.
- R7: At execute, if the writeback stage writes the index of Rn or Rm, that write's data is used instead of the captured value. The stage's own pending result takes priority over `fwd_*`.
- R8: At decode, a writeback-stage write to Rn or Rm overrides `rs_data_a` or `rs_data_b` before capture.
- R9: While `stall` is 1 there is no writeback, the accumulator holds, the instruction waiting at execute stays and `instr` is ignored. The waiting operands keep taking forwarded data, and the instruction executes at the first edge with `stall` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes decode-to-execute register and accumulator |
| instr_valid | input | 1 | `instr` holds a real instruction this cycle |
| instr | input | 32 | Instruction word in the decode stage |
| rs_idx_a | output | 4 | Register file read index for Rn |
| rs_idx_b | output | 4 | Register file read index for Rm |
| rs_data_a | input | 32 | Register file value at `rs_idx_a` |
| rs_data_b | input | 32 | Register file value at `rs_idx_b` |
| fwd_valid | input | 1 | Core's writeback stage is writing a register |
| fwd_idx | input | 4 | Index written by the core's writeback stage |
| fwd_data | input | 32 | Data written by the core's writeback stage |
| wb_valid | output | 1 | Writeback request flag |
| wb_idx | output | 4 | Writeback destination index (Rd) |
| wb_data | output | 32 | Writeback data (d) |

## Verification
The bench targets words that differ from the accepted one by a single field: sub-opcode 0 and 3, a flipped prefix bit, and an invalid strobe. A decoder that checks too few bits would write back and disturb the accumulator on these, and a later result would show it. Chained and one-cycle-gapped dependent instructions, plus core forwarding at both stages, expose a missing or mis-prioritised bypass through stale operand data. A stall test sends a forwarded value during the stall and offers a second instruction. A design that stops refreshing held operands returns the stale value. One that executes during the stall or samples `instr` emits an extra or early writeback. Wide operands check that the multiply wraps and that the right shift is logical.

// File: rtl/xu_pkg.sv
package xu_pkg;
    localparam int XU_IW    = 32;
    localparam int XU_RIW   = 4;
    localparam logic [15:0] XU_PREFIX    = 16'h0D54;
    localparam logic [3:0]  XU_SUB_FUSED = 4'h2;
    localparam logic [19:0] XU_MATCH     = {XU_PREFIX, XU_SUB_FUSED};

    typedef struct packed {
        logic [XU_RIW-1:0] rd;
        logic [XU_RIW-1:0] rn;
        logic [XU_RIW-1:0] rm;
    } xu_fields_t;
endpackage

// File: rtl/xu_decode.sv
module xu_decode
    import xu_pkg::*;
(
    input  logic             instr_valid,
    input  logic [XU_IW-1:0] instr,
    output logic             match,
    output xu_fields_t       fields
);
    localparam int KEY_LSB = XU_IW - $bits(XU_MATCH);

    always_comb begin
        match     = instr_valid && (instr[XU_IW-1:KEY_LSB] == XU_MATCH);
        fields.rd = instr[3*XU_RIW-1:2*XU_RIW];
        fields.rn = instr[2*XU_RIW-1:XU_RIW];
        fields.rm = instr[XU_RIW-1:0];
    end
endmodule

// File: rtl/xu_bypass.sv
module xu_bypass #(
    parameter int XLEN = 32,
    parameter int RIW  = 4
) (
    input  logic [RIW-1:0]  idx,
    input  logic [XLEN-1:0] base,
    input  logic            src_valid,
    input  logic [RIW-1:0]  src_idx,
    input  logic [XLEN-1:0] src_data,
    output logic [XLEN-1:0] val
);
    always_comb begin
        val = (src_valid && (src_idx == idx)) ? src_data : base;
    end
endmodule

// File: rtl/xu_fuse.sv
module xu_fuse #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] acc,
    output logic [XLEN-1:0] d
);
    logic [XLEN-1:0] prod;
    logic [XLEN-1:0] shsum;

    always_comb begin
        prod  = a * b;
        shsum = (a << 2) + (b >> 1);
        d     = prod + shsum + acc;
    end
endmodule

// File: rtl/xunit.sv
module xunit
    import xu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              instr_valid,
    input  logic [XU_IW-1:0]  instr,
    output logic [XU_RIW-1:0] rs_idx_a,
    output logic [XU_RIW-1:0] rs_idx_b,
    input  logic [XLEN-1:0]   rs_data_a,
    input  logic [XLEN-1:0]   rs_data_b,
    input  logic              fwd_valid,
    input  logic [XU_RIW-1:0] fwd_idx,
    input  logic [XLEN-1:0]   fwd_data,
    output logic              wb_valid,
    output logic [XU_RIW-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic                       de_valid;
        xu_fields_t                 de_f;
        logic [NOPS-1:0][XLEN-1:0]  de_op;
        logic                       wb_valid;
        logic [XU_RIW-1:0]          wb_idx;
        logic [XLEN-1:0]            wb_data;
        logic [XLEN-1:0]            acc;
    } xu_state_t;

    xu_state_t st_d, st_q;

    logic       dc_match;
    xu_fields_t dc_f;

    logic                      src_valid;
    logic [XU_RIW-1:0]         src_idx;
    logic [XLEN-1:0]           src_data;

    logic [NOPS-1:0][XU_RIW-1:0] dc_idx;
    logic [NOPS-1:0][XLEN-1:0]   dc_base;
    logic [NOPS-1:0][XLEN-1:0]   dc_val;
    logic [NOPS-1:0][XU_RIW-1:0] ex_idx;
    logic [NOPS-1:0][XLEN-1:0]   ex_val;

    logic [XLEN-1:0] ex_result;

    // internal views for the bound checker
    logic              de_valid_q;
    logic [XU_RIW-1:0] de_rd_q;
    logic [XLEN-1:0]   acc_q;

    xu_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .match       (dc_match),
        .fields      (dc_f)
    );

    // writeback-stage source: own pending result wins over the core's
    always_comb begin
        src_valid = st_q.wb_valid || fwd_valid;
        src_idx   = st_q.wb_valid ? st_q.wb_idx  : fwd_idx;
        src_data  = st_q.wb_valid ? st_q.wb_data : fwd_data;
    end

    assign dc_idx[0]  = dc_f.rn;
    assign dc_idx[1]  = dc_f.rm;
    assign dc_base[0] = rs_data_a;
    assign dc_base[1] = rs_data_b;
    assign ex_idx[0]  = st_q.de_f.rn;
    assign ex_idx[1]  = st_q.de_f.rm;

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        xu_bypass #(.XLEN(XLEN), .RIW(XU_RIW)) u_byp_dc (
            .idx       (dc_idx[g]),
            .base      (dc_base[g]),
            .src_valid (src_valid),
            .src_idx   (src_idx),
            .src_data  (src_data),
            .val       (dc_val[g])
        );
        xu_bypass #(.XLEN(XLEN), .RIW(XU_RIW)) u_byp_ex (
            .idx       (ex_idx[g]),
            .base      (st_q.de_op[g]),
            .src_valid (src_valid),
            .src_idx   (src_idx),
            .src_data  (src_data),
            .val       (ex_val[g])
        );
    end

    xu_fuse #(.XLEN(XLEN)) u_fuse (
        .a   (ex_val[0]),
        .b   (ex_val[1]),
        .acc (st_q.acc),
        .d   (ex_result)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wb_valid = 1'b0;
        if (stall) begin
            // hold the waiting instruction, keep its operands current
            st_d.de_op = ex_val;
        end else begin
            if (st_q.de_valid) begin
                st_d.wb_valid = 1'b1;
                st_d.wb_idx   = st_q.de_f.rd;
                st_d.wb_data  = ex_result;
                st_d.acc      = ex_result;
            end
            st_d.de_valid = dc_match;
            st_d.de_f     = dc_f;
            st_d.de_op    = dc_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rs_idx_a   = dc_f.rn;
    assign rs_idx_b   = dc_f.rm;
    assign wb_valid   = st_q.wb_valid;
    assign wb_idx     = st_q.wb_idx;
    assign wb_data    = st_q.wb_data;
    assign de_valid_q = st_q.de_valid;
    assign de_rd_q    = st_q.de_f.rd;
    assign acc_q      = st_q.acc;
endmodule

// File: rtl/xunit_chk.sv
module xunit_chk
    import xu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              instr_valid,
    input logic [XU_IW-1:0]  instr,
    input logic              de_valid_q,
    input logic [XU_RIW-1:0] de_rd_q,
    input logic              wb_valid,
    input logic [XU_RIW-1:0] wb_idx,
    input logic [XLEN-1:0]   wb_data,
    input logic [XLEN-1:0]   acc_q
);
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && instr_valid && instr[31:12] == XU_MATCH) |=> de_valid_q);

    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !(instr_valid && instr[31:12] == XU_MATCH)) |=> !de_valid_q);

    a_r4_execute: assert property (@(posedge clk) disable iff (!rst_n)
        (de_valid_q && !stall) |=> (wb_valid && wb_idx == $past(de_rd_q)));

    a_r5_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (acc_q == wb_data));

    a_r5_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> $stable(acc_q));

    a_r6_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wb_valid && acc_q == '0));

    a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !wb_valid);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(acc_q) && de_valid_q == $past(de_valid_q)));
endmodule

bind xunit xunit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .instr_valid (instr_valid),
    .instr       (instr),
    .de_valid_q  (de_valid_q),
    .de_rd_q     (de_rd_q),
    .wb_valid    (wb_valid),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .acc_q       (acc_q)
);

// File: tb/xunit_test.sv
`timescale 1ns/1ps
module xunit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic        instr_valid;
    logic [31:0] instr;
    logic [3:0]  rs_idx_a, rs_idx_b;
    logic [31:0] rs_data_a, rs_data_b;
    logic        fwd_valid;
    logic [3:0]  fwd_idx;
    logic [31:0] fwd_data;
    logic        wb_valid;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] m_acc;

    always #2.5 clk = ~clk;

    xunit uut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .instr_valid(instr_valid), .instr(instr),
        .rs_idx_a(rs_idx_a), .rs_idx_b(rs_idx_b),
        .rs_data_a(rs_data_a), .rs_data_b(rs_data_b),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_data(fwd_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] enc(input logic [3:0] sub, input logic [3:0] rd,
                                        input logic [3:0] rn, input logic [3:0] rm);
        return {16'h0D54, sub, rd, rn, rm};
    endfunction

    function automatic logic [31:0] fused(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] acc);
        logic [31:0] p;
        p = a * b;
        return p + (a << 2) + (b >> 1) + acc;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        instr_valid = 1'b0; instr = '0;
        rs_data_a = '0; rs_data_b = '0;
        fwd_valid = 1'b0; fwd_idx = '0; fwd_data = '0;
    endtask

    // present a word for one decode cycle, return just after its capture edge
    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr_valid = 1'b1; instr = w; rs_data_a = a; rs_data_b = b;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stall = 1'b0; idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
        m_acc = '0;
        // first result must include a zero accumulator
        issue(enc(4'h2, 4'h1, 4'h2, 4'h3), 32'd4, 32'd6);
        @(negedge clk);
        chk("R6", "first result, acc zero", wb_data, fused(32'd4, 32'd6, 32'd0));
        m_acc = fused(32'd4, 32'd6, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] av [3] = '{32'd3, 32'hFFFF_FFFF, 32'h8000_0001};
        logic [31:0] bv [3] = '{32'd5, 32'd2, 32'hFFFF_FFFF};
        for (int i = 0; i < 3; i++) begin
            logic [31:0] e;
            e = fused(av[i], bv[i], m_acc);
            issue(enc(4'h2, 4'(i + 10), 4'h1, 4'h2), av[i], bv[i]);
            chk("R4", "no wb one edge after accept", {31'd0, wb_valid}, 32'd0);
            @(negedge clk);
            chk("R4", "wb_valid", {31'd0, wb_valid}, 32'd1);
            chk("R4", "wb_idx is Rd", {28'd0, wb_idx}, 32'(i + 10));
            chk("R3", "fused result", wb_data, e);
            m_acc = e;
            @(negedge clk);
            chk("R4", "single-cycle wb", {31'd0, wb_valid}, 32'd0);
        end
    endtask

    task automatic t_index();
        @(negedge clk);
        instr_valid = 1'b0;
        instr = enc(4'h2, 4'h3, 4'h7, 4'hC);
        #1;
        chk("R2", "rs_idx_a is Rn", {28'd0, rs_idx_a}, 32'h7);
        chk("R2", "rs_idx_b is Rm", {28'd0, rs_idx_b}, 32'hC);
        @(negedge clk);
        idle_inputs();
        chk("R1", "invalid strobe ignored", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        chk("R1", "invalid strobe ignored", {31'd0, wb_valid}, 32'd0);
    endtask

    task automatic t_nomatch();
        logic [31:0] bad [3] = '{enc(4'h0, 4'h1, 4'h1, 4'h1),
                                 enc(4'h3, 4'h1, 4'h1, 4'h1),
                                 enc(4'h2, 4'h1, 4'h1, 4'h1) ^ 32'h0100_0000};
        for (int i = 0; i < 3; i++) begin
            issue(bad[i], 32'd9, 32'd9);
            chk("R1", "rejected word, no wb", {31'd0, wb_valid}, 32'd0);
            @(negedge clk);
            chk("R1", "rejected word, no wb", {31'd0, wb_valid}, 32'd0);
        end
        issue(enc(4'h2, 4'h4, 4'h1, 4'h1), 32'd1, 32'd1);
        @(negedge clk);
        chk("R1", "acc untouched by rejected words", wb_data, fused(32'd1, 32'd1, m_acc));
        m_acc = fused(32'd1, 32'd1, m_acc);
    endtask

    task automatic t_chain();
        logic [31:0] d1, d2;
        d1 = fused(32'd10, 32'd20, m_acc);
        d2 = fused(d1, 32'd3, d1);
        @(negedge clk);
        instr_valid = 1'b1; instr = enc(4'h2, 4'h5, 4'h1, 4'h2);
        rs_data_a = 32'd10; rs_data_b = 32'd20;
        @(negedge clk);
        instr = enc(4'h2, 4'h6, 4'h5, 4'h2);
        rs_data_a = 32'hDEAD_BEEF; rs_data_b = 32'd3;
        @(negedge clk);
        idle_inputs();
        chk("R4", "first chained wb idx", {28'd0, wb_idx}, 32'd5);
        chk("R3", "first chained result", wb_data, d1);
        @(negedge clk);
        chk("R7", "exec bypass of own result", wb_data, d2);
        chk("R5", "acc chains back-to-back", {31'd0, wb_valid}, 32'd1);
        m_acc = d2;
    endtask

    task automatic t_gap();
        logic [31:0] da, db;
        da = fused(32'd2, 32'd2, m_acc);
        db = fused(32'd7, da, da);
        issue(enc(4'h2, 4'h9, 4'h1, 4'h1), 32'd2, 32'd2);
        @(negedge clk);
        chk("R3", "producer result", wb_data, da);
        instr_valid = 1'b1; instr = enc(4'h2, 4'h8, 4'h3, 4'h9);
        rs_data_a = 32'd7; rs_data_b = 32'h0000_1234;
        @(negedge clk);
        idle_inputs();
        chk("R4", "no wb between", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        chk("R8", "decode bypass of own result", wb_data, db);
        m_acc = db;
    endtask

    task automatic t_fwd();
        logic [31:0] e;
        e = fused(32'd77, 32'd55, m_acc);
        @(negedge clk);
        instr_valid = 1'b1; instr = enc(4'h2, 4'h2, 4'h4, 4'h8);
        rs_data_a = 32'd100; rs_data_b = 32'd200;
        fwd_valid = 1'b1; fwd_idx = 4'h8; fwd_data = 32'd55;
        @(negedge clk);
        idle_inputs();
        fwd_valid = 1'b1; fwd_idx = 4'h4; fwd_data = 32'd77;
        @(negedge clk);
        idle_inputs();
        chk("R8", "decode bypass from core", wb_data, e);
        chk("R7", "exec bypass from core", {28'd0, wb_idx}, 32'd2);
        m_acc = e;
    endtask

    task automatic t_stall();
        logic [31:0] e, z;
        e = fused(32'd1000, 32'd9, m_acc);
        z = fused(32'd0, 32'd0, e);
        issue(enc(4'h2, 4'hE, 4'h2, 4'h3), 32'd6, 32'd9);
        stall = 1'b1;
        instr_valid = 1'b1; instr = enc(4'h2, 4'h1, 4'h1, 4'h1);
        rs_data_a = 32'd1; rs_data_b = 32'd1;
        fwd_valid = 1'b1; fwd_idx = 4'h2; fwd_data = 32'd1000;
        @(negedge clk);
        chk("R9", "no wb while stalled", {31'd0, wb_valid}, 32'd0);
        fwd_valid = 1'b0;
        @(negedge clk);
        chk("R9", "no wb while stalled", {31'd0, wb_valid}, 32'd0);
        stall = 1'b0; idle_inputs();
        @(negedge clk);
        chk("R9", "wb after stall", {31'd0, wb_valid}, 32'd1);
        chk("R9", "held operand refreshed", wb_data, e);
        @(negedge clk);
        chk("R9", "word during stall ignored", {31'd0, wb_valid}, 32'd0);
        issue(enc(4'h2, 4'h0, 4'h5, 4'h6), 32'd0, 32'd0);
        @(negedge clk);
        chk("R5", "acc equals last result", wb_data, z);
        m_acc = z;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_index();
        t_nomatch();
        t_chain();
        t_gap();
        t_fwd();
        t_stall();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule